// File: doc/BRIEF.md
# I2C SCL Bit-Period Generator

This block paces the clock line of an I2C master. A sequencer raises an enable, and the block answers with single-cycle strobes. One strobe says when to pull SCL low and another says when to let it go. A third, in the middle of the low half, says when SDA may change. A fourth, in the middle of the high half, says when to sample. A level output tells the pad driver to hold SCL low. A busy flag stays high from the first low half until the last high half has ended.

Each half period lasts PRESCALE × S × T clock cycles. PRESCALE is a fixed divider set by a parameter, which produces the source tick. T is the step count: the inner counter counts T source ticks. S is the sample count: the outer counter counts S inner wraps. S and T come from one of two timing words, and each word stores both values minus one. The standard/fast word allows up to 8 × 64. The high-speed word allows up to 8 × 8 and takes effect only when its key bits are set. A slave may stretch the clock by holding SCL low after release. The block then holds its high-half count until it sees the line high. The timing words are captured only while the block is idle.

Top module: `scl_timer`

## Requirements
- R1: After reset, busy, the drive-low level and all four strobes are 0.
- R2: When the high-speed word is not selected, S = sf_timing_i[10:8] + 1 and T = sf_timing_i[5:0] + 1. All other bits of that word have no effect. With no stretching, one full bit (low half plus high half) takes 2 × PRESCALE × S × T cycles.
- R3: The high-speed word is selected when hs_timing_i[1:0] = 2'b11. Then S = hs_timing_i[14:12] + 1, T = hs_timing_i[10:8] + 1, and sf_timing_i has no effect. Any other key value, including an all-zero word, leaves the high-speed word without effect.
- R4: When the block is idle and run_i is 1 at a clock edge, then in the next cycle busy_o is 1, scl_drive_low_o is 1 and tick_low_o pulses.
- R5: After PRESCALE × S × T cycles of a low half, tick_release_o pulses for one cycle and scl_drive_low_o drops to 0 in that same cycle.
- R6: tick_drive_o pulses once per low half, PRESCALE × T × (floor((S−1)/2)+1) cycles after the half began. When S = 1 this coincides with the release strobe.
- R7: tick_sample_o pulses once per high half, at the same offset into that half as tick_drive_o in the low half.
- R8: During a high half, any clock edge at which scl_i is 0 does not advance the count. Each such edge lengthens the bit by one cycle.
- R9: At the end of a high half, a new low half starts at once with tick_low_o if run_i is 1. Otherwise busy_o falls, so dropping run_i lets the current bit finish.
- R10: Changes to either timing word while busy_o is 1 have no effect on the bit period until the block has gone idle and started again.
- R11: The value of scl_i during a low half has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_timing_i | input | 16 | Standard/fast timing word |
| hs_timing_i | input | 16 | High-speed timing word and key |
| run_i | input | 1 | Keep generating bits while 1 |
| scl_i | input | 1 | SCL level observed on the bus |
| scl_drive_low_o | output | 1 | 1 while the block pulls SCL low |
| tick_low_o | output | 1 | Strobe: a low half begins |
| tick_release_o | output | 1 | Strobe: SCL is released |
| tick_drive_o | output | 1 | Strobe: middle of the low half, SDA may change |
| tick_sample_o | output | 1 | Strobe: middle of the high half, sample SDA |
| busy_o | output | 1 | A bit is in progress |

## Verification
The assertions hold the following on every cycle. A start follows an enable seen while idle. Release strobes line up with the falling edge of the drive-low level. Drive and sample strobes fall in the correct half. An idle block is silent. A bus held low in the high half emits no sample or low strobe. The captured timing stays frozen while busy. Other properties are only visible over whole bit periods, so the bench scenarios show them: the field decode of both words, the selection by key bits, the exact mid-point offsets, the stretch extension, and the deferred effect of a timing change. A behavioural model compares every strobe on every cycle, and the bench also measures periods between low strobes.

// File: rtl/scl_timer_pkg.sv
package scl_timer_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SAMP_W      = 3;
  localparam int unsigned STEP_W      = 6;
  localparam int unsigned HS_STEP_W   = 3;
  localparam int unsigned SF_SAMP_LSB = 8;
  localparam int unsigned SF_STEP_LSB = 0;
  localparam int unsigned HS_SAMP_LSB = 12;
  localparam int unsigned HS_STEP_LSB = 8;
  localparam int unsigned HS_KEY_W    = 2;
  localparam logic [HS_KEY_W-1:0] HS_KEY = 2'b11;

  typedef struct packed {
    logic [SAMP_W-1:0] samp_m1;
    logic [STEP_W-1:0] step_m1;
  } half_cfg_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] sf_word_i,
  input  logic [WORD_W-1:0] hs_word_i,
  output half_cfg_t         cfg_o
);
  logic      hs_sel;
  half_cfg_t decoded;
  half_cfg_t cfg_d;
  half_cfg_t cfg_q;
  logic      unused_word_bits;

  // Parity over the words keeps fields that carry no timing visibly consumed.
  assign unused_word_bits = ^{sf_word_i, hs_word_i};

  always_comb begin
    hs_sel = (hs_word_i[HS_KEY_W-1:0] == HS_KEY);
    if (hs_sel) begin
      decoded.samp_m1 = hs_word_i[HS_SAMP_LSB +: SAMP_W];
      decoded.step_m1 = {{(STEP_W-HS_STEP_W){1'b0}}, hs_word_i[HS_STEP_LSB +: HS_STEP_W]};
    end else begin
      decoded.samp_m1 = sf_word_i[SF_SAMP_LSB +: SAMP_W];
      decoded.step_m1 = sf_word_i[SF_STEP_LSB +: STEP_W];
    end
    cfg_d = load_i ? decoded : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign tick_o = en_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else if (en_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_half_counter.sv
module scl_half_counter #(
  parameter int unsigned SAMP_W = 3,
  parameter int unsigned STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [SAMP_W-1:0] samp_m1_i,
  input  logic [STEP_W-1:0] step_m1_i,
  output logic              mid_o,
  output logic              done_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic [SAMP_W-1:0] samp_q, samp_d;
  logic              step_wrap;
  logic              outer_last;
  logic              outer_mid;

  assign step_wrap  = (step_q == step_m1_i);
  assign outer_last = (samp_q == samp_m1_i);
  assign outer_mid  = (samp_q == (samp_m1_i >> 1));
  assign mid_o      = adv_i && step_wrap && outer_mid;
  assign done_o     = adv_i && step_wrap && outer_last;

  always_comb begin
    step_d = step_q;
    samp_d = samp_q;
    if (clr_i || done_o) begin
      step_d = '0;
      samp_d = '0;
    end else if (adv_i) begin
      if (step_wrap) begin
        step_d = '0;
        samp_d = samp_q + 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      samp_q <= '0;
    end else begin
      step_q <= step_d;
      samp_q <= samp_d;
    end
  end
endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import scl_timer_pkg::*;
#(
  parameter int unsigned PRESCALE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] sf_timing_i,
  input  logic [15:0] hs_timing_i,
  input  logic        run_i,
  input  logic        scl_i,
  output logic        scl_drive_low_o,
  output logic        tick_low_o,
  output logic        tick_release_o,
  output logic        tick_drive_o,
  output logic        tick_sample_o,
  output logic        busy_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  scl_phase_e state_q, state_d;
  logic drive_low_q, drive_low_d;
  logic t_low_q, t_low_d;
  logic t_rel_q, t_rel_d;
  logic t_drv_q, t_drv_d;
  logic t_smp_q, t_smp_d;

  logic      idle;
  logic      freeze;
  logic      src_en;
  logic      src_tick;
  logic      half_mid;
  logic      half_done;
  half_cfg_t half_cfg;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign idle   = (state_q == PH_IDLE);
  assign freeze = (state_q == PH_HIGH) && !scl_i;
  assign src_en = !idle && !freeze;

  scl_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (idle),
    .sf_word_i (sf_timing_i),
    .hs_word_i (hs_timing_i),
    .cfg_o     (half_cfg)
  );

  scl_prescale #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (idle),
    .en_i   (src_en),
    .tick_o (src_tick)
  );

  scl_half_counter #(.SAMP_W(SAMP_W), .STEP_W(STEP_W)) u_half (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_i     (idle),
    .adv_i     (src_tick),
    .samp_m1_i (half_cfg.samp_m1),
    .step_m1_i (half_cfg.step_m1),
    .mid_o     (half_mid),
    .done_o    (half_done)
  );

  always_comb begin
    state_d     = state_q;
    drive_low_d = drive_low_q;
    t_low_d     = 1'b0;
    t_rel_d     = 1'b0;
    t_drv_d     = 1'b0;
    t_smp_d     = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (run_i) begin
          state_d     = PH_LOW;
          drive_low_d = 1'b1;
          t_low_d     = 1'b1;
        end
      end
      PH_LOW: begin
        t_drv_d = half_mid;
        if (half_done) begin
          state_d     = PH_HIGH;
          drive_low_d = 1'b0;
          t_rel_d     = 1'b1;
        end
      end
      PH_HIGH: begin
        t_smp_d = half_mid;
        if (half_done) begin
          if (run_i) begin
            state_d     = PH_LOW;
            drive_low_d = 1'b1;
            t_low_d     = 1'b1;
          end else begin
            state_d = PH_IDLE;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= PH_IDLE;
      drive_low_q <= 1'b0;
      t_low_q     <= 1'b0;
      t_rel_q     <= 1'b0;
      t_drv_q     <= 1'b0;
      t_smp_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      drive_low_q <= drive_low_d;
      t_low_q     <= t_low_d;
      t_rel_q     <= t_rel_d;
      t_drv_q     <= t_drv_d;
      t_smp_q     <= t_smp_d;
    end
  end

  assign scl_drive_low_o = drive_low_q;
  assign tick_low_o      = t_low_q;
  assign tick_release_o  = t_rel_q;
  assign tick_drive_o    = t_drv_q;
  assign tick_sample_o   = t_smp_q;
  assign busy_o          = !idle;
endmodule

// File: rtl/scl_timer_checker.sv
module scl_timer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run_i,
  input logic       scl_i,
  input logic       busy_o,
  input logic       scl_drive_low_o,
  input logic       tick_low_o,
  input logic       tick_release_o,
  input logic       tick_drive_o,
  input logic       tick_sample_o,
  input logic [2:0] cfg_samp,
  input logic [5:0] cfg_step
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (!scl_drive_low_o && !tick_release_o && !tick_drive_o));

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && run_i) |=> (busy_o && scl_drive_low_o && tick_low_o));

  assert_release_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_release_o |-> (!scl_drive_low_o && $past(scl_drive_low_o)));

  assert_low_release_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_low_o, tick_release_o}));

  assert_drive_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_drive_o |-> (scl_drive_low_o || tick_release_o));

  assert_sample_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample_o |-> (!scl_drive_low_o || tick_low_o));

  assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !scl_drive_low_o && !scl_i) |=> (busy_o && !tick_sample_o && !tick_low_o));

  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_drive_low_o && !tick_drive_o && !tick_release_o && !tick_low_o));

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(cfg_samp) && $stable(cfg_step)));
endmodule

bind scl_timer scl_timer_checker u_scl_timer_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .run_i           (run_i),
  .scl_i           (scl_i),
  .busy_o          (busy_o),
  .scl_drive_low_o (scl_drive_low_o),
  .tick_low_o      (tick_low_o),
  .tick_release_o  (tick_release_o),
  .tick_drive_o    (tick_drive_o),
  .tick_sample_o   (tick_sample_o),
  .cfg_samp        (half_cfg.samp_m1),
  .cfg_step        (half_cfg.step_m1)
);

// File: tb/scl_timer_tb_top.sv
`timescale 1ns/1ps
module scl_timer_tb_top;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] sf_w;
  logic [15:0] hs_w;
  logic        run;
  logic        scl;
  logic        drv_low, t_low, t_rel, t_drv, t_smp, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  scl_timer #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .sf_timing_i(sf_w), .hs_timing_i(hs_w),
    .run_i(run), .scl_i(scl), .scl_drive_low_o(drv_low), .tick_low_o(t_low),
    .tick_release_o(t_rel), .tick_drive_o(t_drv), .tick_sample_o(t_smp), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: one elapsed-tick count per half, integer arithmetic.
  int m_s, m_t, m_pre, m_k;
  bit m_busy, m_high, m_oe, m_tl, m_rel, m_drv, m_smp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_high = 0; m_oe = 0; m_tl = 0; m_rel = 0; m_drv = 0; m_smp = 0;
      m_pre = 0; m_k = 0; m_s = 1; m_t = 1;
    end else begin
      m_tl = 0; m_rel = 0; m_drv = 0; m_smp = 0;
      if (!m_busy) begin
        if ((hs_w % 4) == 3) begin
          m_s = ((hs_w >> 12) % 8) + 1;
          m_t = ((hs_w >> 8) % 8) + 1;
        end else begin
          m_s = ((sf_w >> 8) % 8) + 1;
          m_t = (sf_w % 64) + 1;
        end
        if (run) begin
          m_busy = 1; m_high = 0; m_oe = 1; m_tl = 1; m_pre = 0; m_k = 0;
        end
      end else if (!(m_high && !scl)) begin
        m_pre++;
        if (m_pre == P) begin
          m_pre = 0;
          m_k++;
          if (m_k == m_t * ((m_s - 1) / 2 + 1)) begin
            if (m_high) m_smp = 1; else m_drv = 1;
          end
          if (m_k == m_s * m_t) begin
            m_k = 0;
            if (!m_high) begin
              m_high = 1; m_oe = 0; m_rel = 1;
            end else if (run) begin
              m_high = 0; m_oe = 1; m_tl = 1;
            end else begin
              m_busy = 0;
            end
          end
        end
      end
    end
  end

  // Monitor, comparator and bus model, all at the falling edge.
  int cyc = 0, last_low = 0, last_period = 0, n_lows = 0, n_idle = 0, idle_gap = 0;
  int stretch_amt = 0, stretch_left = 0;
  bit noise = 0, busy_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy    == m_busy, "R9 busy",         busy,    m_busy);
      chk(drv_low == m_oe,   "R5 drive_low",    drv_low, m_oe);
      chk(t_low   == m_tl,   "R4 tick_low",     t_low,   m_tl);
      chk(t_rel   == m_rel,  "R5 tick_release", t_rel,   m_rel);
      chk(t_drv   == m_drv,  "R6 tick_drive",   t_drv,   m_drv);
      chk(t_smp   == m_smp,  "R7 tick_sample",  t_smp,   m_smp);
    end
    if (t_low) begin
      last_period = cyc - last_low;
      last_low = cyc;
      n_lows++;
    end
    if (busy_prev && !busy) begin
      idle_gap = cyc - last_low;
      n_idle++;
    end
    busy_prev = busy;
    if (t_rel && stretch_amt > 0) stretch_left = stretch_amt;
    if (stretch_left > 0) begin
      scl = 1'b0;
      stretch_left--;
    end else if (noise && drv_low) begin
      scl = cyc[0];
    end else begin
      scl = !drv_low;
    end
  end

  task automatic wait_lows(input int n);
    int target;
    target = n_lows + n;
    do begin @(posedge clk); #1; end while (n_lows < target);
  endtask

  task automatic stop_run(input int exp_gap, input string tag);
    int target;
    target = n_idle + 1;
    run = 1'b0;
    do begin @(posedge clk); #1; end while (n_idle < target);
    if (exp_gap > 0) chk(idle_gap == exp_gap, tag, idle_gap, exp_gap);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic period_case(input logic [15:0] sf, input logic [15:0] hs,
                             input int exp, input string tag);
    sf_w = sf; hs_w = hs; run = 1'b1;
    wait_lows(3);
    chk(last_period == exp, tag, last_period, exp);
    stop_run(exp, {tag, " R9 finish"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; scl = 1'b1; sf_w = 16'h0000; hs_w = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    // R1: quiet after reset
    chk({busy, drv_low, t_low, t_rel, t_drv, t_smp} == 6'b0, "R1 reset state",
        {busy, drv_low, t_low, t_rel, t_drv, t_smp}, 0);

    // R2: S=3, T=5
    period_case(16'h0204, 16'h0000, 2*P*15, "R2 period 3x5");
    // R2: S=1, T=1 with unused bits set
    period_case(16'hF8C0, 16'h0000, 2*P*1, "R2 period 1x1 junk bits");
    // R2: largest counts S=8, T=64
    period_case(16'h073F, 16'h0000, 2*P*512, "R2 period 8x64");
    // R3: high-speed key set, S=6, T=8, standard word ignored
    period_case(16'h0000, 16'h5703, 2*P*48, "R3 hs selected");
    // R3: key not set, standard word S=2, T=2 used
    period_case(16'h0101, 16'h5702, 2*P*4, "R3 hs not keyed");
    period_case(16'h0300, 16'h0000, 2*P*4, "R3 hs zero word");

    // R8: slave holds SCL low 7 extra edges after each release
    stretch_amt = 7;
    sf_w = 16'h0204; hs_w = 16'h0000; run = 1'b1;
    wait_lows(3);
    chk(last_period == 2*P*15 + 7, "R8 stretched period", last_period, 2*P*15 + 7);
    stretch_amt = 0;
    stop_run(0, "R8 finish");

    // R10: change word while busy
    sf_w = 16'h0204; run = 1'b1;
    wait_lows(2);
    sf_w = 16'h0000;
    wait_lows(2);
    chk(last_period == 2*P*15, "R10 busy change ignored", last_period, 2*P*15);
    stop_run(2*P*15, "R10 finish old timing");
    run = 1'b1;
    wait_lows(3);
    chk(last_period == 2*P*1, "R10 new timing after restart", last_period, 2*P*1);
    stop_run(2*P*1, "R10 finish new timing");

    // R11: SCL toggling during low half
    noise = 1;
    sf_w = 16'h0204; run = 1'b1;
    wait_lows(3);
    chk(last_period == 2*P*15, "R11 low-half noise", last_period, 2*P*15);
    noise = 0;
    stop_run(2*P*15, "R11 finish");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule